// File: doc/BRIEF.md
# Link CRC Error Monitor

This block watches the symbols arriving over a serial link and decides whether each one arrived intact. Every symbol brings a 16-bit payload and a 4-bit check code. The monitor recomputes the check code from the payload and compares it with the received code. A disagreement on a symbol that counts is a link error.

Errors are counted in a saturating counter. A sticky status line `pass_ok_o` falls on the first counted error and stays low until software clears it. An interrupt pulse fires once, when the count first reaches a programmable threshold. Checking only takes place while the receiver reports lock. Dropping lock discards everything gathered so far, because symbols seen without lock say nothing about the health of the link.

The integrating logic drives `lock_i` from the clock-recovery circuit and `threshold_i` from a configuration register. It routes `irq_o` to the host interrupt controller and pulses `clear_i` when the error condition has been handled.

Top module: `link_crc_monitor`

## Requirements
- R1: The check code is the CRC with generator x^4+x+1 (taps 4'b0011) and an all-zero start value. It is computed with the payload bits entered most-significant first, with no reflection and no final inversion. For payload 16'h0001 the code is 4'h3. A symbol is erroneous when `crc_rx_i` differs from the computed code.
- R2: A symbol is evaluated only in a cycle where `sym_valid_i` and `lock_i` are both 1. With `sym_valid_i` at 0, or with `lock_i` at 0, a wrong code changes neither `err_count_o`, nor `pass_ok_o`, nor `irq_o`.
- R3: Each erroneous evaluated symbol raises `err_count_o` by exactly one. The new value appears after the next rising clock edge. A symbol with a correct code leaves the count unchanged.
- R4: While `lock_i` is 0, the count is forced to 0 and `pass_ok_o` to 1 after the next clock edge.
- R5: The count saturates at 2^CNT_W-1 (255 by default). Further erroneous symbols leave it there and raise no interrupt.
- R6: `clear_i` at 1 sets the count to 0 and `pass_ok_o` to 1 after the next clock edge. It takes priority over an erroneous symbol in the same cycle.
- R7: `pass_ok_o` goes to 0 one cycle after the first counted error. It stays 0 through later correct symbols until a clear or a loss of lock.
- R8: `irq_o` is a one-cycle pulse. It is high in the cycle after an erroneous symbol brings the count up to the effective threshold, and at no other time.
- R9: A `threshold_i` of 0 behaves as a threshold of 1.
- R10: After reset, `err_count_o` is 0, `pass_ok_o` is 1 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lock_i | input | 1 | Receiver lock; 0 disables checking and discards errors |
| sym_valid_i | input | 1 | A symbol is present on the data inputs this cycle |
| payload_i | input | 16 | Received symbol payload |
| crc_rx_i | input | 4 | Received check code |
| threshold_i | input | 8 | Error count that raises the interrupt (0 acts as 1) |
| clear_i | input | 1 | Clears the count and the error status |
| pass_ok_o | output | 1 | 1 while no error has been counted, 0 after an error |
| irq_o | output | 1 | One-cycle pulse when the count reaches the threshold |
| err_count_o | output | 8 | Saturating count of erroneous symbols |

## Verification
A corrupted count register shows on `err_count_o` in the very next cycle. It also skews the instant of the interrupt pulse, which then comes early, late, twice or never against the threshold. A lost or spuriously set error flag shows on `pass_ok_o` one cycle after the symbol that should have moved it. A wrong check-code computation only shows when a payload reaches the port. The stimulus therefore mixes literal known codes, payloads with all-zero and all-one bits, and corrupted codes with single-bit and multi-bit errors.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

  // Default geometry of the monitored symbol and the error counter
  localparam int unsigned LCM_PAYLOAD_W = 16;
  localparam int unsigned LCM_CRC_W     = 4;
  localparam int unsigned LCM_CNT_W     = 8;
  // Generator x^4 + x + 1 without its leading term
  localparam logic [LCM_CRC_W-1:0] LCM_POLY = 4'b0011;

  // Classification of one cycle's symbol
  typedef enum logic [1:0] {
    SYM_IDLE = 2'd0,
    SYM_GOOD = 2'd1,
    SYM_BAD  = 2'd2
  } sym_class_e;

endpackage

// File: rtl/lcm_rst_sync.sv
module lcm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/lcm_crc_calc.sv
module lcm_crc_calc #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CRC_W  = 4,
  parameter logic [CRC_W-1:0] POLY = 4'b0011
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);

  // Bit-serial division unrolled over the payload, MSB entered first
  always_comb begin
    logic [CRC_W-1:0] rem;
    logic             fb;
    rem = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb  = rem[CRC_W-1] ^ data_i[i];
      rem = {rem[CRC_W-2:0], 1'b0};
      if (fb) rem = rem ^ POLY;
    end
    crc_o = rem;
  end

endmodule

// File: rtl/lcm_sym_check.sv
module lcm_sym_check
  import lcm_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CRC_W  = 4,
  parameter logic [CRC_W-1:0] POLY = 4'b0011
) (
  input  logic              valid_i,
  input  logic              lock_i,
  input  logic [DATA_W-1:0] payload_i,
  input  logic [CRC_W-1:0]  crc_rx_i,
  output sym_class_e        class_o
);

  logic [CRC_W-1:0] crc_calc;

  lcm_crc_calc #(
    .DATA_W (DATA_W),
    .CRC_W  (CRC_W),
    .POLY   (POLY)
  ) u_crc (
    .data_i (payload_i),
    .crc_o  (crc_calc)
  );

  always_comb begin
    if (!(valid_i && lock_i))      class_o = SYM_IDLE;
    else if (crc_calc == crc_rx_i) class_o = SYM_GOOD;
    else                           class_o = SYM_BAD;
  end

endmodule

// File: rtl/lcm_err_counter.sv
module lcm_err_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_i,
  input  logic             clr_i,
  input  logic             bad_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] thr_eff;
  logic             cnt_en;
  logic             irq_q, irq_d;
  logic             at_max;

  assign thr_eff = (thr_i == '0) ? CNT_ONE : thr_i;
  assign at_max  = (cnt_q == CNT_MAX);

  // Next state: flush beats clear beats increment
  always_comb begin
    cnt_d  = cnt_q;
    irq_d  = 1'b0;
    cnt_en = 1'b0;
    if (!lock_i || clr_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (bad_i && !at_max) begin
      cnt_d  = cnt_q + CNT_ONE;
      cnt_en = 1'b1;
      irq_d  = (cnt_d == thr_eff);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R4
  unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_i |=> (cnt_q == '0));

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && clr_i) |=> (cnt_q == '0));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !clr_i && at_max) |=> (cnt_q == CNT_MAX));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !clr_i) |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_ONE)));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

endmodule

// File: rtl/lcm_status_flag.sv
module lcm_status_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic clr_i,
  input  logic bad_i,
  output logic pass_ok_o
);

  logic err_q, err_d, err_en;

  always_comb begin
    err_d  = err_q;
    err_en = 1'b0;
    if (!lock_i || clr_i) begin
      err_d  = 1'b0;
      err_en = 1'b1;
    end else if (bad_i) begin
      err_d  = 1'b1;
      err_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign pass_ok_o = ~err_q;

  // R7
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_ok_o && lock_i && !clr_i) |=> !pass_ok_o);

  // R7
  pass_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_i && lock_i && !clr_i) |=> !pass_ok_o);

endmodule

// File: rtl/link_crc_monitor.sv
module link_crc_monitor
  import lcm_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = LCM_PAYLOAD_W,
  parameter int unsigned CRC_W     = LCM_CRC_W,
  parameter int unsigned CNT_W     = LCM_CNT_W,
  parameter logic [CRC_W-1:0] POLY = LCM_POLY
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lock_i,
  input  logic                 sym_valid_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  input  logic [CRC_W-1:0]     crc_rx_i,
  input  logic [CNT_W-1:0]     threshold_i,
  input  logic                 clear_i,
  output logic                 pass_ok_o,
  output logic                 irq_o,
  output logic [CNT_W-1:0]     err_count_o
);

  logic       rst_int_n;
  sym_class_e sym_class;
  logic       sym_bad;

  lcm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lcm_sym_check #(
    .DATA_W (PAYLOAD_W),
    .CRC_W  (CRC_W),
    .POLY   (POLY)
  ) u_check (
    .valid_i   (sym_valid_i),
    .lock_i    (lock_i),
    .payload_i (payload_i),
    .crc_rx_i  (crc_rx_i),
    .class_o   (sym_class)
  );

  assign sym_bad = (sym_class == SYM_BAD);

  lcm_err_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lock_i (lock_i),
    .clr_i  (clear_i),
    .bad_i  (sym_bad),
    .thr_i  (threshold_i),
    .cnt_o  (err_count_o),
    .irq_o  (irq_o)
  );

  lcm_status_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lock_i    (lock_i),
    .clr_i     (clear_i),
    .bad_i     (sym_bad),
    .pass_ok_o (pass_ok_o)
  );

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!sym_valid_i && lock_i && !clear_i) |=> $stable(err_count_o));

endmodule

// File: tb/link_crc_monitor_tb.sv
module link_crc_monitor_tb;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        lock_i;
  logic        sym_valid_i;
  logic [15:0] payload_i;
  logic [3:0]  crc_rx_i;
  logic [7:0]  threshold_i;
  logic        clear_i;
  logic        pass_ok_o;
  logic        irq_o;
  logic [7:0]  err_count_o;

  int n_chk;
  int n_bad;

  link_crc_monitor u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_i      (lock_i),
    .sym_valid_i (sym_valid_i),
    .payload_i   (payload_i),
    .crc_rx_i    (crc_rx_i),
    .threshold_i (threshold_i),
    .clear_i     (clear_i),
    .pass_ok_o   (pass_ok_o),
    .irq_o       (irq_o),
    .err_count_o (err_count_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Reference code by long division of the augmented payload
  function automatic logic [3:0] ref_crc(input logic [15:0] pl);
    logic [19:0] v;
    v = {pl, 4'b0000};
    for (int i = 19; i >= 4; i--)
      if (v[i]) v[i -: 5] = v[i -: 5] ^ 5'b10011;
    return v[3:0];
  endfunction

  typedef struct packed {
    logic [15:0] pl;
    logic [3:0]  flip;
    logic        vld;
    logic        lck;
    logic [7:0]  cnt;
    logic        pass;
    logic        irq;
  } vec_t;

  // Threshold 3 while this table runs
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 4'h0, 1'b1, 1'b1, 8'd0, 1'b1, 1'b0},  // R1 good
    '{16'hFFFF, 4'h0, 1'b1, 1'b1, 8'd0, 1'b1, 1'b0},  // R1 good
    '{16'hA5A5, 4'h1, 1'b1, 1'b1, 8'd1, 1'b0, 1'b0},  // R3 R7
    '{16'hFFFF, 4'h8, 1'b0, 1'b1, 8'd1, 1'b0, 1'b0},  // R2 not valid
    '{16'h0000, 4'h0, 1'b1, 1'b1, 8'd1, 1'b0, 1'b0},  // R7 holds
    '{16'h8001, 4'h4, 1'b1, 1'b1, 8'd2, 1'b0, 1'b0},  // R3
    '{16'h7E7E, 4'hF, 1'b1, 1'b1, 8'd3, 1'b0, 1'b1},  // R8 reaches 3
    '{16'h0F0F, 4'h2, 1'b1, 1'b1, 8'd4, 1'b0, 1'b0},  // R8 no repeat
    '{16'h1111, 4'h1, 1'b1, 1'b0, 8'd0, 1'b1, 1'b0},  // R4 unlock
    '{16'h2222, 4'h1, 1'b1, 1'b0, 8'd0, 1'b1, 1'b0},  // R2 unlocked
    '{16'h3333, 4'h0, 1'b1, 1'b1, 8'd0, 1'b1, 1'b0},  // R1 good
    '{16'h4444, 4'h6, 1'b1, 1'b1, 8'd1, 1'b0, 1'b0}   // R3
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge
  task automatic sym(input logic [15:0] pl, input logic [3:0] flip,
                     input logic vld, input logic lck, input logic clr);
    payload_i   = pl;
    crc_rx_i    = ref_crc(pl) ^ flip;
    sym_valid_i = vld;
    lock_i      = lck;
    clear_i     = clr;
    @(posedge clk);
    @(negedge clk);
    clear_i     = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int pulses;
    n_chk = 0;
    n_bad = 0;
    rst_n       = 1'b0;
    lock_i      = 1'b1;
    sym_valid_i = 1'b0;
    payload_i   = '0;
    crc_rx_i    = '0;
    threshold_i = 8'd3;
    clear_i     = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 count", int'(err_count_o), 0);
    check("R10 pass", int'(pass_ok_o), 1);
    check("R10 irq", int'(irq_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      sym(VECS[k].pl, VECS[k].flip, VECS[k].vld, VECS[k].lck, 1'b0);
      check($sformatf("R3 vec%0d count", k), int'(err_count_o), int'(VECS[k].cnt));
      check($sformatf("R7 vec%0d pass", k), int'(pass_ok_o), int'(VECS[k].pass));
      check($sformatf("R8 vec%0d irq", k), int'(irq_o), int'(VECS[k].irq));
    end

    // R6: clear beats a same-cycle error
    sym(16'hBEEF, 4'h3, 1'b1, 1'b1, 1'b1);
    check("R6 count", int'(err_count_o), 0);
    check("R6 pass", int'(pass_ok_o), 1);

    // R1: literal code for payload 0x0001 is 3
    payload_i = 16'h0001; crc_rx_i = 4'h3; sym_valid_i = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 literal good", int'(err_count_o), 0);
    crc_rx_i = 4'h0;
    @(posedge clk); @(negedge clk);
    check("R1 literal bad", int'(err_count_o), 1);
    sym(16'h0, 4'h0, 1'b1, 1'b1, 1'b1);

    // R9: threshold 0 acts as 1
    threshold_i = 8'd0;
    sym(16'h5A5A, 4'h8, 1'b1, 1'b1, 1'b0);
    check("R9 irq", int'(irq_o), 1);
    check("R9 count", int'(err_count_o), 1);
    sym(16'h5A5A, 4'h0, 1'b1, 1'b1, 1'b0);
    check("R9 irq falls", int'(irq_o), 0);

    // R7: pass stays low through good symbols until clear
    repeat (3) sym(16'hC3C3, 4'h0, 1'b1, 1'b1, 1'b0);
    check("R7 sticky", int'(pass_ok_o), 0);
    sym(16'hC3C3, 4'h0, 1'b0, 1'b1, 1'b1);
    check("R7 cleared", int'(pass_ok_o), 1);

    // R5: saturation, single pulse at threshold 200
    threshold_i = 8'd200;
    pulses = 0;
    for (int k = 0; k < 260; k++) begin
      sym(16'(k * 97), 4'h5, 1'b1, 1'b1, 1'b0);
      if (irq_o) pulses++;
      if (k == 199) check("R8 irq at 200", int'(irq_o), 1);
    end
    check("R5 saturated", int'(err_count_o), 255);
    check("R8 single pulse", pulses, 1);
    sym(16'h0101, 4'h1, 1'b1, 1'b1, 1'b0);
    check("R5 held", int'(err_count_o), 255);
    check("R5 no irq", int'(irq_o), 0);

    // R4: loss of lock flushes the saturated state
    sym(16'h0101, 4'h1, 1'b0, 1'b0, 1'b0);
    check("R4 count", int'(err_count_o), 0);
    check("R4 pass", int'(pass_ok_o), 1);

    finish_run();
  end

endmodule